// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a simple register port and a serial shift engine. It buffers outgoing words in a transmit FIFO and incoming words in a receive FIFO. Both FIFOs are `DW` bits wide and `DEPTH` entries deep, with 32 or 64 as the usual depths. Software sees the fill level of each FIFO, two programmable thresholds, a status word, and an interrupt set: a raw register, a mask register and a masked register. Error flags are removed through a write-one-to-clear register. A single registered `irq` line is the OR of the masked sources.

The serial engine pops transmit words and pushes received words through a handful of strobes. It reports its own busy and select-inactive conditions to the unit. Writing 0 to the enable bit stops the controller and empties both FIFOs. The threshold registers are locked while the controller is enabled.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: After reset the enable bit, both thresholds, the mask and all sticky flags are zero. Both FIFOs are empty, so the status word reads 0x000C and the raw interrupt word reads 0x0001.
- R2: Each FIFO delivers words in the order written. The level registers return the current entry count. A pop strobe from the engine places the next transmit word on `eng_tx_data` one cycle later.
- R3: The status word has these bits: bit 0 busy (engine busy, or enabled with transmit data queued), bit 1 TX full, bit 2 TX empty, bit 3 RX empty, bit 4 RX full, bit 5 engine slave-transmit busy.
- R4: Raw bit 0 is high while the transmit level is less than or equal to the TX threshold.
- R5: Raw bit 4 is high while the receive level is greater than the RX threshold T, that is, from T+1 entries upward.
- R6: A write to the TX data address while the transmit FIFO is full is dropped and sets sticky raw bit 1.
- R7: A read of the RX data address while the receive FIFO is empty returns 0 and sets sticky raw bit 2. An engine push into a full receive FIFO is dropped and sets sticky raw bit 3.
- R8: A pulse on `eng_cs_inactive` sets sticky raw bit 6.
- R9: Writing the clear register has these effects: bit 0 clears every sticky flag, bit 1 clears bit 2, bit 2 clears bit 3, and bit 3 clears bit 1. A flag set in the same cycle stays set.
- R10: The masked word equals raw AND mask. `irq` is the OR of the masked word, registered one cycle later. A zero mask keeps `irq` low.
- R11: Writes to either threshold register are ignored while the enable bit is 1.
- R12: Writing 0 to the enable bit empties both FIFOs. Sticky flags are kept.
- R13: The register word addresses are 0 enable (bit 0), 1 TX threshold, 2 RX threshold, 3 TX level, 4 RX level, 5 status, 6 mask, 7 masked, 8 raw, 9 clear, 10 TX data (write), 11 RX data (read). Read data appears on `reg_rdata` with `reg_rvalid` one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 write, 0 read |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the request |
| reg_rvalid | output | 1 | Read data valid |
| eng_enable | output | 1 | Controller enable to the engine |
| eng_tx_pop | input | 1 | Engine takes a transmit word |
| eng_tx_data | output | DW | Transmit word, valid the cycle after a pop |
| eng_tx_avail | output | 1 | Transmit FIFO not empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DW | Received word |
| eng_busy | input | 1 | Engine is shifting |
| eng_slv_tx_busy | input | 1 | Engine in slave mode still transmitting |
| eng_cs_inactive | input | 1 | Select went inactive (pulse) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with `DEPTH` = 8 and `DW` = 16. With that depth, full, overflow and RX-full conditions are reached after eight or nine accesses, so the boundary where a write is dropped can be checked directly. Threshold values of 2 (TX) and 1 (RX) place both level interrupts in the middle of the small range, where the inclusive and exclusive comparisons give different answers.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int REG_AW = 4;
  localparam int IRQ_W  = 7;
  localparam int STAT_W = 6;

  // register word addresses
  localparam logic [REG_AW-1:0] A_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] A_TXTHR = 4'd1;
  localparam logic [REG_AW-1:0] A_RXTHR = 4'd2;
  localparam logic [REG_AW-1:0] A_TXLVL = 4'd3;
  localparam logic [REG_AW-1:0] A_RXLVL = 4'd4;
  localparam logic [REG_AW-1:0] A_STAT  = 4'd5;
  localparam logic [REG_AW-1:0] A_MASK  = 4'd6;
  localparam logic [REG_AW-1:0] A_MIS   = 4'd7;
  localparam logic [REG_AW-1:0] A_RIS   = 4'd8;
  localparam logic [REG_AW-1:0] A_CLR   = 4'd9;
  localparam logic [REG_AW-1:0] A_TXD   = 4'd10;
  localparam logic [REG_AW-1:0] A_RXD   = 4'd11;

  // interrupt source bit positions
  localparam int IB_TXTHR = 0;
  localparam int IB_TXOVF = 1;
  localparam int IB_RXUNF = 2;
  localparam int IB_RXOVF = 3;
  localparam int IB_RXTHR = 4;
  localparam int IB_CSI   = 6;

  // clear register bit positions
  localparam int CB_ALL   = 0;
  localparam int CB_RXUNF = 1;
  localparam int CB_RXOVF = 2;
  localparam int CB_TXOVF = 3;

  // status bit positions
  localparam int SB_BUSY   = 0;
  localparam int SB_TXFULL = 1;
  localparam int SB_TXEMP  = 2;
  localparam int SB_RXEMP  = 3;
  localparam int SB_RXFULL = 4;
  localparam int SB_SLVTX  = 5;
endpackage

// File: rtl/spi_sfifo.sv
module spi_sfifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [$clog2(DEPTH):0] level,
  output logic          full,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = PW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full      = (cnt == LW'(DEPTH));
  assign empty     = (cnt == '0);
  assign push_ok   = push && !full;
  assign pop_ok    = pop && !empty;
  assign push_drop = push && full;
  assign pop_empty = pop && empty;
  assign level     = cnt;

  // storage: write port only, read through a register for RAM inference
  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (pop) begin
      rdata <= pop_ok ? mem[rd_ptr] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + LW'(push_ok) - LW'(pop_ok);
    end
  end
endmodule

// File: rtl/spi_irq_core.sv
module spi_irq_core
  import spi_fifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_thr_hit,
  input  logic             rx_thr_hit,
  input  logic             tx_ovf_set,
  input  logic             rx_unf_set,
  input  logic             rx_ovf_set,
  input  logic             cs_set,
  input  logic             clr_stb,
  input  logic [3:0]       clr_bits,
  input  logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] masked,
  output logic             irq
);
  logic tx_ovf_q, rx_unf_q, rx_ovf_q, cs_q;
  logic clr_all, clr_txovf, clr_rxunf, clr_rxovf;

  assign clr_all   = clr_stb && clr_bits[CB_ALL];
  assign clr_txovf = clr_all || (clr_stb && clr_bits[CB_TXOVF]);
  assign clr_rxunf = clr_all || (clr_stb && clr_bits[CB_RXUNF]);
  assign clr_rxovf = clr_all || (clr_stb && clr_bits[CB_RXOVF]);

  // sticky flags: a set in the same cycle overrides a clear
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_ovf_q <= 1'b0;
      rx_unf_q <= 1'b0;
      rx_ovf_q <= 1'b0;
      cs_q     <= 1'b0;
    end else begin
      tx_ovf_q <= tx_ovf_set || (tx_ovf_q && !clr_txovf);
      rx_unf_q <= rx_unf_set || (rx_unf_q && !clr_rxunf);
      rx_ovf_q <= rx_ovf_set || (rx_ovf_q && !clr_rxovf);
      cs_q     <= cs_set     || (cs_q && !clr_all);
    end
  end

  always_comb begin
    raw           = '0;
    raw[IB_TXTHR] = tx_thr_hit;
    raw[IB_TXOVF] = tx_ovf_q;
    raw[IB_RXUNF] = rx_unf_q;
    raw[IB_RXOVF] = rx_ovf_q;
    raw[IB_RXTHR] = rx_thr_hit;
    raw[IB_CSI]   = cs_q;
  end

  assign masked = raw & mask;

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |masked;
  end
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              reg_rvalid,
  output logic              eng_enable,
  input  logic              eng_tx_pop,
  output logic [DW-1:0]     eng_tx_data,
  output logic              eng_tx_avail,
  input  logic              eng_rx_push,
  input  logic [DW-1:0]     eng_rx_data,
  input  logic              eng_busy,
  input  logic              eng_slv_tx_busy,
  input  logic              eng_cs_inactive,
  output logic              irq
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic             en_q;
  logic [LW-1:0]    tx_thr_q, rx_thr_q;
  logic [IRQ_W-1:0] mask_q;
  logic [31:0]      rdata_q;
  logic             sel_rx_q, rvalid_q;

  logic             wr_stb, rd_stb, flush;
  logic             tx_push, rx_pop;
  logic [LW-1:0]    tx_level, rx_level;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_drop, tx_pop_empty, rx_drop, rx_unf;
  logic [DW-1:0]    rx_rd;
  logic [STAT_W-1:0] status;
  logic [IRQ_W-1:0] raw_flags, masked_flags;

  assign wr_stb  = reg_valid && reg_write;
  assign rd_stb  = reg_valid && !reg_write;
  assign flush   = wr_stb && (reg_addr == A_CTRL) && !reg_wdata[0];
  assign tx_push = wr_stb && (reg_addr == A_TXD);
  assign rx_pop  = rd_stb && (reg_addr == A_RXD);

  spi_sfifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(flush),
    .push(tx_push), .wdata(reg_wdata[DW-1:0]),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .push_drop(tx_drop), .pop_empty(tx_pop_empty)
  );

  spi_sfifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(rx_pop), .rdata(rx_rd),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .push_drop(rx_drop), .pop_empty(rx_unf)
  );

  spi_irq_core u_irq (
    .clk(clk), .rst(rst),
    .tx_thr_hit(tx_level <= tx_thr_q),
    .rx_thr_hit(rx_level > rx_thr_q),
    .tx_ovf_set(tx_drop),
    .rx_unf_set(rx_unf),
    .rx_ovf_set(rx_drop && !flush),
    .cs_set(eng_cs_inactive),
    .clr_stb(wr_stb && (reg_addr == A_CLR)),
    .clr_bits(reg_wdata[3:0]),
    .mask(mask_q),
    .raw(raw_flags),
    .masked(masked_flags),
    .irq(irq)
  );

  // control registers; thresholds locked while enabled
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
      mask_q   <= '0;
    end else if (wr_stb) begin
      case (reg_addr)
        A_CTRL:  en_q   <= reg_wdata[0];
        A_MASK:  mask_q <= reg_wdata[IRQ_W-1:0];
        A_TXTHR: if (!en_q) tx_thr_q <= reg_wdata[LW-1:0];
        A_RXTHR: if (!en_q) rx_thr_q <= reg_wdata[LW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    status            = '0;
    status[SB_BUSY]   = eng_busy || (en_q && !tx_empty);
    status[SB_TXFULL] = tx_full;
    status[SB_TXEMP]  = tx_empty;
    status[SB_RXEMP]  = rx_empty;
    status[SB_RXFULL] = rx_full;
    status[SB_SLVTX]  = eng_slv_tx_busy;
  end

  // registered read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      sel_rx_q <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_stb;
      sel_rx_q <= rx_pop;
      if (rd_stb) begin
        case (reg_addr)
          A_CTRL:  rdata_q <= 32'(en_q);
          A_TXTHR: rdata_q <= 32'(tx_thr_q);
          A_RXTHR: rdata_q <= 32'(rx_thr_q);
          A_TXLVL: rdata_q <= 32'(tx_level);
          A_RXLVL: rdata_q <= 32'(rx_level);
          A_STAT:  rdata_q <= 32'(status);
          A_MASK:  rdata_q <= 32'(mask_q);
          A_MIS:   rdata_q <= 32'(masked_flags);
          A_RIS:   rdata_q <= 32'(raw_flags);
          default: rdata_q <= '0;
        endcase
      end
    end
  end

  assign reg_rdata    = sel_rx_q ? 32'(rx_rd) : rdata_q;
  assign reg_rvalid   = rvalid_q;
  assign eng_enable   = en_q;
  assign eng_tx_avail = !tx_empty;
endmodule

// File: rtl/spi_fifo_irq_chk.sv
module spi_fifo_irq_chk
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LW    = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              eng_rx_push,
  input logic [LW-1:0]     tx_level,
  input logic [LW-1:0]     rx_level,
  input logic [IRQ_W-1:0]  raw_flags,
  input logic [IRQ_W-1:0]  mask_q,
  input logic              en_q,
  input logic [LW-1:0]     tx_thr_q,
  input logic              irq
);
  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

  // R6
  tx_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && reg_write && reg_addr == A_TXD && tx_level == LW'(DEPTH))
    |=> raw_flags[IB_TXOVF]);

  // R7
  rx_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_push && rx_level == LW'(DEPTH) &&
     !(reg_valid && reg_write && reg_addr == A_CTRL && !reg_wdata[0]))
    |=> raw_flags[IB_RXOVF]);

  // R10
  mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq);

  // R11
  thr_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (en_q && reg_valid && reg_write && reg_addr == A_TXTHR) |=> $stable(tx_thr_q));

  // R12
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && reg_write && reg_addr == A_CTRL && !reg_wdata[0])
    |=> (tx_level == '0) && (rx_level == '0));
endmodule

bind spi_fifo_irq_unit spi_fifo_irq_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .eng_rx_push(eng_rx_push),
  .tx_level(tx_level), .rx_level(rx_level), .raw_flags(raw_flags),
  .mask_q(mask_q), .en_q(en_q), .tx_thr_q(tx_thr_q), .irq(irq)
);

// File: tb/tb_spi_fifo_irq_unit.sv
module tb_spi_fifo_irq_unit;
  import spi_fifo_pkg::*;

  localparam int DEPTH = 8;
  localparam int DW    = 16;
  localparam int NV    = 30;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_valid = 1'b0, reg_write = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic              reg_rvalid, eng_enable, eng_tx_avail, irq;
  logic              eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
  logic [DW-1:0]     eng_tx_data;
  logic [DW-1:0]     eng_rx_data = '0;
  logic              eng_busy = 1'b0, eng_slv_tx_busy = 1'b0, eng_cs_inactive = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_fifo_irq_unit #(.DEPTH(DEPTH), .DW(DW)) dut (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .eng_enable(eng_enable), .eng_tx_pop(eng_tx_pop),
    .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_busy(eng_busy),
    .eng_slv_tx_busy(eng_slv_tx_busy), .eng_cs_inactive(eng_cs_inactive), .irq(irq)
  );

  // {is_read, requirement, address, write data or expected read data}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 4'd1,  A_STAT,  16'h000C},  // R1
    {1'b1, 4'd1,  A_RIS,   16'h0001},  // R1
    {1'b1, 4'd1,  A_CTRL,  16'h0000},  // R1
    {1'b0, 4'd4,  A_TXTHR, 16'h0002},
    {1'b0, 4'd5,  A_RXTHR, 16'h0001},
    {1'b1, 4'd4,  A_TXTHR, 16'h0002},  // R4
    {1'b0, 4'd2,  A_TXD,   16'h00A1},
    {1'b0, 4'd2,  A_TXD,   16'h00A2},
    {1'b0, 4'd2,  A_TXD,   16'h00A3},
    {1'b1, 4'd2,  A_TXLVL, 16'h0003},  // R2
    {1'b1, 4'd4,  A_RIS,   16'h0000},  // R4 level 3 above threshold 2
    {1'b0, 4'd13, A_CTRL,  16'h0001},
    {1'b1, 4'd13, A_CTRL,  16'h0001},  // R13
    {1'b0, 4'd11, A_TXTHR, 16'h0007},
    {1'b1, 4'd11, A_TXTHR, 16'h0002},  // R11
    {1'b0, 4'd2,  A_TXD,   16'h00A4},
    {1'b0, 4'd2,  A_TXD,   16'h00A5},
    {1'b0, 4'd2,  A_TXD,   16'h00A6},
    {1'b0, 4'd2,  A_TXD,   16'h00A7},
    {1'b0, 4'd2,  A_TXD,   16'h00A8},
    {1'b1, 4'd3,  A_STAT,  16'h000B},  // R3 busy, tx full, rx empty
    {1'b0, 4'd6,  A_TXD,   16'h00FF},
    {1'b1, 4'd6,  A_RIS,   16'h0002},  // R6
    {1'b1, 4'd6,  A_TXLVL, 16'h0008},  // R6 write dropped
    {1'b0, 4'd9,  A_CLR,   16'h0008},
    {1'b1, 4'd9,  A_RIS,   16'h0000},  // R9
    {1'b0, 4'd12, A_CTRL,  16'h0000},
    {1'b1, 4'd12, A_TXLVL, 16'h0000},  // R12
    {1'b1, 4'd12, A_STAT,  16'h000C},  // R12
    {1'b1, 4'd4,  A_RIS,   16'h0001}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [REG_AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [REG_AW-1:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic rx_push(input logic [DW-1:0] d);
    @(negedge clk);
    eng_rx_push = 1'b1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 1'b0;
  endtask

  task automatic tx_pop(output logic [DW-1:0] d);
    @(negedge clk);
    eng_tx_pop = 1'b1;
    @(negedge clk);
    eng_tx_pop = 1'b0;
    d = eng_tx_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] td;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq", 32'(irq), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) rd_chk($sformatf("R%0d vec%0d", VEC[i][23:20], i),
                             VEC[i][19:16], 32'(VEC[i][15:0]));
      else wr(VEC[i][19:16], 32'(VEC[i][15:0]));
    end

    // R2 transmit order towards the engine
    wr(A_TXD, 32'h11);
    wr(A_TXD, 32'h22);
    chk("R2 avail", 32'(eng_tx_avail), 32'd1);
    tx_pop(td); chk("R2 first", 32'(td), 32'h11);
    tx_pop(td); chk("R2 second", 32'(td), 32'h22);
    rd_chk("R2 txlvl", A_TXLVL, 32'd0);

    // R5 receive threshold, R2 order, R7 underflow
    rx_push(16'h5A);
    rd_chk("R5 below", A_RIS, 32'h01);
    rx_push(16'h5B);
    rd_chk("R5 above", A_RIS, 32'h11);
    rd_chk("R2 rxlvl", A_RXLVL, 32'd2);
    rd_chk("R2 rx first", A_RXD, 32'h5A);
    rd_chk("R2 rx second", A_RXD, 32'h5B);
    rd_chk("R7 underflow data", A_RXD, 32'h0);
    rd_chk("R7 underflow flag", A_RIS, 32'h05);

    // R10 masking and interrupt line
    @(negedge clk);
    chk("R10 zero mask irq", 32'(irq), 32'd0);
    rd_chk("R10 zero mask mis", A_MIS, 32'h0);
    wr(A_MASK, 32'h04);
    @(negedge clk);
    chk("R10 irq high", 32'(irq), 32'd1);
    rd_chk("R10 mis", A_MIS, 32'h04);
    wr(A_CLR, 32'h02);
    rd_chk("R9 clear unf", A_RIS, 32'h01);
    chk("R9 irq low", 32'(irq), 32'd0);

    // R7 receive overflow, R3 rx full
    for (int k = 0; k < DEPTH + 1; k++) rx_push(16'(k));
    rd_chk("R7 overflow flag", A_RIS, 32'h19);
    rd_chk("R7 rxlvl", A_RXLVL, 32'd8);
    rd_chk("R3 rx full", A_STAT, 32'h14);
    wr(A_CLR, 32'h01);
    rd_chk("R9 clear all", A_RIS, 32'h11);

    // R12 receive flush on disable
    wr(A_CTRL, 32'h1);
    wr(A_RXTHR, 32'h5);
    rd_chk("R11 rx thr locked", A_RXTHR, 32'h1);
    wr(A_CTRL, 32'h0);
    rd_chk("R12 rx flushed", A_RXLVL, 32'd0);

    // R8 select inactive
    @(negedge clk);
    eng_cs_inactive = 1'b1;
    @(negedge clk);
    eng_cs_inactive = 1'b0;
    rd_chk("R8 flag", A_RIS, 32'h41);
    wr(A_MASK, 32'h40);
    @(negedge clk);
    chk("R8 irq", 32'(irq), 32'd1);
    wr(A_CLR, 32'h01);
    rd_chk("R9 clear csi", A_RIS, 32'h01);
    chk("R10 irq drops", 32'(irq), 32'd0);

    // R3 engine-driven status bits
    @(negedge clk);
    eng_busy = 1'b1; eng_slv_tx_busy = 1'b1;
    rd_chk("R3 engine bits", A_STAT, 32'h2D);
    eng_busy = 1'b0; eng_slv_tx_busy = 1'b0;

    finish_run();
  end
endmodule